// File: doc/BRIEF.md
# Page Entry Permission Checker

This block decides whether one memory access may proceed, given the leaf entry that a page table walk returned. It takes the 64-bit entry, the kind of access (load, store or instruction fetch), whether the processor runs in user (problem) state, whether the walk was partition-scoped rather than process-scoped, and a three-bit permission mask from the authority-mask register. It returns the read/write/execute permissions it grants, a three-bit cause vector and a single fault flag.

The entry is decoded from fixed bit positions, because the table format is shared with the walker. Bits 5:4 hold the memory attribute, and the code 2'b10 means non-idempotent I/O. Bit 3 marks the entry as privileged-only. Bits 2, 1 and 0 are the read, write and execute permissions. Every permission vector in the block, including the mask input and the granted output, uses the same order: bit 2 read, bit 1 write, bit 0 execute.

The access code is 0 for a read, 1 for a write and 2 for a fetch. Code 3 counts as a read. The cause vector is bit 0 guarded-no-execute, bit 1 protection and bit 2 store. With the default `REG_OUT = 1`, a registered stage holds the outputs. They then follow the inputs by one clock, and reset clears them.

Top module: `pec_perm_check`

## Requirements
- R1: A fetch (access code 2) to an entry whose bits 5:4 equal 2'b10 faults with cause bit 0 set and cause bit 1 clear, whatever the entry's permission bits and the mask are.
- R2: When the walk is process-scoped (partition flag 0), the entry is privileged (bit 3 = 1) and the access is in user state, the available permission set is empty.
- R3: In user state, for a privileged entry, or for any partition-scoped walk, the available set equals entry bits 2:0, and the mask has no effect.
- R4: For a supervisor access to a non-privileged, process-scoped entry, the available set is entry bits 2:0 ANDed with the mask input.
- R5: If no guarded fault applies and the available set lacks the permission the access needs (bit 2 for a read, bit 1 for a write, bit 0 for a fetch), the block faults with cause bit 1 set.
- R6: Cause bit 2 (store) is set exactly when a fault occurs on a write access. A fetch never sets it.
- R7: Access code 3 behaves exactly like code 0 (read).
- R8: Whenever the fault output is high, the granted permission output is 3'b000. Otherwise it equals the available set.
- R9: With REG_OUT = 1, the outputs show the result for the inputs sampled at the previous rising clock edge. While reset is active, all outputs are zero.
- R10: When the fault output is low, all cause bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| pte_i | input | 64 | Leaf page table entry |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| user_i | input | 1 | Access made in user (problem) state |
| part_i | input | 1 | Walk is partition-scoped |
| amask_i | input | 3 | Authority-mask permissions {read, write, execute} |
| grant_o | output | 3 | Granted permissions {read, write, execute} |
| cause_o | output | 3 | Fault cause {store, protection, guarded-no-execute} |
| fault_o | output | 1 | Access denied |

## Verification
The only state in this block is the output register. If that register holds a wrong value, the error shows at the ports on the very next clock. It can appear as a granted set that is nonzero on a fault, a cause bit set without a fault, or a store bit on a read or a fetch. Errors in the decode that selects the permission source show one cycle later as a grant that reflects the mask when it should not, or the reverse. The stimulus therefore mixes user state, scope, privilege and mask patterns until each selection path has been taken many times.

// File: rtl/pec_pkg.sv
package pec_pkg;
    localparam int PTE_W    = 64;
    localparam int ATTR_LSB = 4;
    localparam int PRIV_BIT = 3;
    localparam int PERM_LSB = 0;
    localparam int PERM_W   = 3;
    localparam logic [1:0] ATTR_NIO = 2'b10;

    // permission vector order: [2] read, [1] write, [0] execute
    typedef logic [PERM_W-1:0] perm_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef struct packed {
        perm_t grant;
        logic  store;
        logic  prot;
        logic  guard;
        logic  fault;
    } result_t;
endpackage

// File: rtl/pec_need.sv
module pec_need
    import pec_pkg::*;
(
    input  acc_e  acc,
    output perm_t need,
    output logic  is_write,
    output logic  is_fetch
);
    always_comb begin
        need     = 3'b100;
        is_write = 1'b0;
        is_fetch = 1'b0;
        unique case (acc)
            ACC_WRITE: begin
                need     = 3'b010;
                is_write = 1'b1;
            end
            ACC_FETCH: begin
                need     = 3'b001;
                is_fetch = 1'b1;
            end
            default: need = 3'b100;
        endcase
    end
endmodule

// File: rtl/pec_grant.sv
module pec_grant
    import pec_pkg::*;
(
    input  perm_t entry_perm,
    input  logic  entry_priv,
    input  logic  user,
    input  logic  part,
    input  perm_t amask,
    output perm_t avail
);
    logic lock_out;
    logic use_raw;

    always_comb begin
        lock_out = !part && entry_priv && user;
        use_raw  = user || entry_priv || part;
        if (lock_out) begin
            avail = '0;
        end else if (use_raw) begin
            avail = entry_perm;
        end else begin
            avail = entry_perm & amask;
        end
    end
endmodule

// File: rtl/pec_fault.sv
module pec_fault
    import pec_pkg::*;
(
    input  logic    nio_attr,
    input  logic    is_fetch,
    input  logic    is_write,
    input  perm_t   need,
    input  perm_t   avail,
    output result_t res
);
    logic guard_hit;
    logic prot_hit;
    logic any;

    always_comb begin
        guard_hit = nio_attr && is_fetch;
        prot_hit  = !guard_hit && ((need & ~avail) != '0);
        any       = guard_hit || prot_hit;
        res.guard = guard_hit;
        res.prot  = prot_hit;
        res.store = any && is_write;
        res.fault = any;
        res.grant = any ? '0 : avail;
    end
endmodule

// File: rtl/pec_perm_check.sv
module pec_perm_check
    import pec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTE_W-1:0] pte_i,
    input  logic [1:0]       acc_i,
    input  logic             user_i,
    input  logic             part_i,
    input  logic [PERM_W-1:0] amask_i,
    output logic [PERM_W-1:0] grant_o,
    output logic [2:0]       cause_o,
    output logic             fault_o
);
    acc_e    acc;
    perm_t   need;
    perm_t   avail;
    logic    is_write;
    logic    is_fetch;
    logic    nio_attr;
    result_t res_d;
    result_t res_out;

    assign acc      = acc_e'(acc_i);
    assign nio_attr = (pte_i[ATTR_LSB +: 2] == ATTR_NIO);

    pec_need u_need (
        .acc      (acc),
        .need     (need),
        .is_write (is_write),
        .is_fetch (is_fetch)
    );

    pec_grant u_grant (
        .entry_perm (pte_i[PERM_LSB +: PERM_W]),
        .entry_priv (pte_i[PRIV_BIT]),
        .user       (user_i),
        .part       (part_i),
        .amask      (amask_i),
        .avail      (avail)
    );

    pec_fault u_fault (
        .nio_attr (nio_attr),
        .is_fetch (is_fetch),
        .is_write (is_write),
        .need     (need),
        .avail    (avail),
        .res      (res_d)
    );

    generate
        if (REG_OUT) begin : g_reg
            result_t res_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_d;
                end
            end
            assign res_out = res_q;
        end else begin : g_comb
            assign res_out = res_d;
        end
    endgenerate

    assign grant_o = res_out.grant;
    assign cause_o = {res_out.store, res_out.prot, res_out.guard};
    assign fault_o = res_out.fault;
endmodule

// File: rtl/pec_perm_check_sva.sv
module pec_perm_check_sva
    import pec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
)(
    input logic             clk,
    input logic             rst_n,
    input logic [PTE_W-1:0] pte_i,
    input logic [1:0]       acc_i,
    input logic             user_i,
    input logic             part_i,
    input logic [PERM_W-1:0] amask_i,
    input logic [PERM_W-1:0] grant_o,
    input logic [2:0]       cause_o,
    input logic             fault_o
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_FAULT_ZERO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> grant_o == '0); // R8
    AST_CLEAN_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_o |-> cause_o == 3'b000); // R10

    generate
        if (REG_OUT) begin : g_seq
            AST_GUARD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
                armed && $past(acc_i == 2'd2 && pte_i[ATTR_LSB +: 2] == ATTR_NIO)
                |-> fault_o && cause_o[0] && !cause_o[1]); // R1
            AST_USER_PRIV_NONE: assert property (@(posedge clk) disable iff (!rst_n)
                armed && $past(user_i && !part_i && pte_i[PRIV_BIT])
                |-> grant_o == '0); // R2
            AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
                armed && !fault_o
                |-> (grant_o & ~$past(pte_i[PERM_LSB +: PERM_W])) == '0); // R3
            AST_STORE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                armed && cause_o[2] |-> fault_o && $past(acc_i) == 2'd1); // R6
        end
    endgenerate
endmodule

bind pec_perm_check pec_perm_check_sva #(.REG_OUT(REG_OUT)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .pte_i   (pte_i),
    .acc_i   (acc_i),
    .user_i  (user_i),
    .part_i  (part_i),
    .amask_i (amask_i),
    .grant_o (grant_o),
    .cause_o (cause_o),
    .fault_o (fault_o)
);

// File: tb/tb_pec_perm_check.sv
module tb_pec_perm_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pte_i = '0;
    logic [1:0]  acc_i = '0;
    logic        user_i = 1'b0;
    logic        part_i = 1'b0;
    logic [2:0]  amask_i = '0;
    logic [2:0]  grant_o;
    logic [2:0]  cause_o;
    logic        fault_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pec_perm_check dut (
        .clk(clk), .rst_n(rst_n), .pte_i(pte_i), .acc_i(acc_i),
        .user_i(user_i), .part_i(part_i), .amask_i(amask_i),
        .grant_o(grant_o), .cause_o(cause_o), .fault_o(fault_o)
    );

    // returns {grant[2:0], cause[2:0], fault}
    function automatic logic [6:0] model(logic [63:0] pte, logic [1:0] acc,
                                         logic usr, logic prt, logic [2:0] am);
        logic [2:0] need, avail;
        logic guard, prot, flt, store;
        need  = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b001 : 3'b100;
        if (!prt && pte[3] && usr)       avail = 3'b000;
        else if (usr || pte[3] || prt)   avail = pte[2:0];
        else                             avail = pte[2:0] & am;
        guard = (pte[5:4] == 2'b10) && (acc == 2'd2);
        prot  = !guard && ((need & ~avail) != 3'b000);
        flt   = guard || prot;
        store = flt && (acc == 2'd1);
        return {flt ? 3'b000 : avail, store, prot, guard, flt};
    endfunction

    task automatic check(string tag, logic [6:0] got, logic [6:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got grant=%b cause=%b fault=%b expected grant=%b cause=%b fault=%b",
                     tag, got[6:4], got[3:1], got[0], exp[6:4], exp[3:1], exp[0]);
        end
    endtask

    task automatic apply(string tag, logic [63:0] pte, logic [1:0] acc,
                         logic usr, logic prt, logic [2:0] am);
        @(negedge clk);
        pte_i = pte; acc_i = acc; user_i = usr; part_i = prt; amask_i = am;
        @(negedge clk);
        check(tag, {grant_o, cause_o, fault_o}, model(pte, acc, usr, prt, am));
    endtask

    function automatic string pick_tag(logic [63:0] pte, logic [1:0] acc,
                                       logic usr, logic prt);
        if (acc == 2'd2 && pte[5:4] == 2'b10) return "R1";
        if (!prt && pte[3] && usr)           return "R2";
        if (acc == 2'd3)                     return "R7";
        if (usr || pte[3] || prt)            return "R3";
        return "R4";
    endfunction

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got running expected finished");
        report();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7721);
        // R9: reset holds outputs at zero even with faulting inputs
        pte_i = 64'h30; acc_i = 2'd1; user_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 reset", {grant_o, cause_o, fault_o}, 7'b0);
        rst_n = 1'b1;
        // R9: one-cycle latency of registered stage
        @(negedge clk);
        pte_i = 64'h7; acc_i = 2'd0; user_i = 1'b1; part_i = 1'b0; amask_i = 3'b000;
        check("R9 before edge", {grant_o, cause_o, fault_o}, model(64'h30, 2'd1, 1'b1, 1'b0, 3'b000));
        @(negedge clk);
        check("R9 after edge", {grant_o, cause_o, fault_o}, 7'b111_000_0);

        apply("R1 guard all perms", 64'h2F, 2'd2, 1'b0, 1'b1, 3'b111);
        apply("R1 guard nothing", 64'h28, 2'd2, 1'b1, 1'b0, 3'b000);
        apply("R1 attr 3 no guard", 64'h37, 2'd2, 1'b1, 1'b0, 3'b000);
        apply("R1 nio read ok", 64'h27, 2'd0, 1'b1, 1'b0, 3'b000);
        apply("R2 user priv read", 64'h0F, 2'd0, 1'b1, 1'b0, 3'b111);
        apply("R2 user priv partition ok", 64'h0F, 2'd0, 1'b1, 1'b1, 3'b000);
        apply("R3 partition mask ignored", 64'h07, 2'd1, 1'b0, 1'b1, 3'b000);
        apply("R3 super priv mask ignored", 64'h0E, 2'd0, 1'b0, 1'b0, 3'b000);
        apply("R4 mask restricts write", 64'h07, 2'd1, 1'b0, 1'b0, 3'b101);
        apply("R4 mask passes", 64'h07, 2'd0, 1'b0, 1'b0, 3'b101);
        apply("R5 fetch no exec", 64'h06, 2'd2, 1'b1, 1'b0, 3'b111);
        apply("R6 write fault store", 64'h05, 2'd1, 1'b1, 1'b0, 3'b111);
        apply("R6 fetch fault no store", 64'h04, 2'd2, 1'b1, 1'b0, 3'b111);
        apply("R7 code3 read ok", 64'h04, 2'd3, 1'b1, 1'b0, 3'b000);
        apply("R7 code3 read fault", 64'h03, 2'd3, 1'b1, 1'b0, 3'b000);
        apply("R8 fault zero grant", 64'h03, 2'd0, 1'b0, 1'b1, 3'b111);
        apply("R10 clean no cause", 64'h01, 2'd2, 1'b0, 1'b1, 3'b000);

        for (int i = 0; i < 3000; i++) begin
            logic [63:0] p;
            logic [1:0]  a;
            logic        u, pt;
            logic [2:0]  m;
            p  = {$urandom(), $urandom()};
            if ($urandom_range(0, 3) == 0) p[5:4] = 2'b10;
            a  = 2'($urandom_range(0, 3));
            u  = 1'($urandom_range(0, 1));
            pt = 1'($urandom_range(0, 1));
            m  = 3'($urandom_range(0, 7));
            apply({pick_tag(p, a, u, pt), " random R5 R6 R8 R10"}, p, a, u, pt, m);
        end
        report();
    end
endmodule